// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This block drives the single remote-control output pin of a small controller with an infrared carrier. Software picks one of four shapes with a 2-bit mode select and turns the output on and off with a 1-bit latch value. Three shapes are square-ish carriers derived from the system clock by fixed division: divide by 12 with 4 high clocks, divide by 12 with 3 high clocks, and divide by 8 with 4 high clocks. The fourth shape has no carrier, and the pin simply follows the latch.

The pin stays low whenever the latch is low. When the latch rises, the divider starts again from the first clock of a period, so every burst begins with a complete high phase. The block samples a new mode select only at a period boundary, or while the latch is low, so it never cuts a pulse short. The pin is a registered output, which keeps decode glitches away from the LED driver.

Top module: `ir_carrier_gen`

## Requirements
- R1: While `rst_n` is low, and after reset while `latch_in` stays low, `carrier_out` is 0.
- R2: When `latch_in` has been low for two clock edges, `carrier_out` is 0 for every value of `mode_sel`.
- R3: With `mode_sel` = 2'b00, the output repeats with a period of 12 clocks and is high for the first 4 clocks of each period.
- R4: With `mode_sel` = 2'b01, the output repeats with a period of 12 clocks and is high for the first 3 clocks of each period.
- R5: With `mode_sel` = 2'b10, the output repeats with a period of 8 clocks and is high for the first 4 clocks of each period.
- R6: With `mode_sel` = 2'b11, `carrier_out` equals the `latch_in` value sampled two clock edges earlier.
- R7: The first rising edge that samples `latch_in` high restarts the divider. From the next edge on, `carrier_out` shows a complete period that starts with its high phase.
- R8: A `mode_sel` change while the latch is high takes effect only at the first period boundary of the running mode. While the latch is low, `mode_sel` is taken at every edge, so the mode present at the rising edge governs the burst.
- R9: When `latch_in` falls in the middle of a high phase, `carrier_out` goes low two edges after the edge that samples the low value, and it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that the carrier is divided from |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Carrier shape: 00 div12 4-high, 01 div12 3-high, 10 div8 4-high, 11 no carrier |
| latch_in | input | 1 | Output latch value that enables the pin |
| carrier_out | output | 1 | Registered remote output pin |

## Verification
Every result of the block is due two edges after the edge that samples its cause. The latch register takes one edge and the output register takes the other. Sample s of a burst therefore belongs to divider count s and shows on the pin after edge k+1+s, where k is the edge that first samples the latch high. A mode change written after sample s reaches the divider at count s+2, so the bench computes the switch point as the next multiple of the old period at or after that count. The bench drives inputs and samples the pin on the falling edge, so each check reads a value that has been settled for half a cycle.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

   // Shape codes written by software; decode order is fixed behaviour.
   typedef enum logic [1:0] {
      CM_DIV12_THIRD   = 2'b00,
      CM_DIV12_QUARTER = 2'b01,
      CM_DIV8_HALF     = 2'b10,
      CM_STEADY        = 2'b11
   } carrier_mode_e;

   localparam int unsigned NUM_SHAPED = 3;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/ir_period_counter.sv
// Free-running period counter, cleared while idle or at its terminal value.
module ir_period_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_zero,
   input  logic [CNT_W-1:0] last_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("ir_period_counter: CNT_W must be at least 1");
      end
   endgenerate

   assign wrap = (cnt == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (hold_zero || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3: the count never passes the terminal value of the shape in force.
   a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_val);

   // R7: a held counter sits at zero on the following edge.
   a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hold_zero |=> (cnt == '0));

endmodule

// File: rtl/ir_phase_decode.sv
// Maps (shape, count) to the high-phase flag and the shape's terminal count.
module ir_phase_decode
   import ir_carrier_pkg::*;
#(
   parameter int unsigned CNT_W        = 4,
   parameter int unsigned PER_THIRD    = 12,
   parameter int unsigned HIGH_THIRD   = 4,
   parameter int unsigned PER_QUARTER  = 12,
   parameter int unsigned HIGH_QUARTER = 3,
   parameter int unsigned PER_HALF     = 8,
   parameter int unsigned HIGH_HALF    = 4
) (
   input  carrier_mode_e    mode,
   input  logic [CNT_W-1:0] cnt,
   output logic             phase_high,
   output logic [CNT_W-1:0] last_val
);

   localparam int unsigned PERS  [NUM_SHAPED] = '{PER_THIRD, PER_QUARTER, PER_HALF};
   localparam int unsigned HIGHS [NUM_SHAPED] = '{HIGH_THIRD, HIGH_QUARTER, HIGH_HALF};

   logic [NUM_SHAPED-1:0] shape_hit;
   logic [CNT_W-1:0]      shape_last [NUM_SHAPED];

   generate
      for (genvar g = 0; g < NUM_SHAPED; g++) begin : g_shape
         if (PERS[g] < 2) begin : g_bad_per
            $error("ir_phase_decode: each period needs at least two clocks");
         end
         if (HIGHS[g] < 1 || HIGHS[g] >= PERS[g]) begin : g_bad_high
            $error("ir_phase_decode: high phase must be shorter than its period");
         end
         if (PERS[g] > (1 << CNT_W)) begin : g_bad_fit
            $error("ir_phase_decode: counter too narrow for period");
         end
         assign shape_hit[g]  = (cnt < CNT_W'(HIGHS[g]));
         assign shape_last[g] = CNT_W'(PERS[g] - 1);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         CM_DIV12_THIRD: begin
            phase_high = shape_hit[0];
            last_val   = shape_last[0];
         end
         CM_DIV12_QUARTER: begin
            phase_high = shape_hit[1];
            last_val   = shape_last[1];
         end
         CM_DIV8_HALF: begin
            phase_high = shape_hit[2];
            last_val   = shape_last[2];
         end
         default: begin
            // No carrier: a one-clock period that is always high.
            phase_high = 1'b1;
            last_val   = '0;
         end
      endcase
   end

endmodule

// File: rtl/ir_mode_holder.sv
// Holds the shape in force; it reloads only when the sequencer allows it.
module ir_mode_holder
   import ir_carrier_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  carrier_mode_e mode_in,
   output carrier_mode_e mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CM_STEADY;
      end else if (load) begin
         mode_q <= mode_in;
      end
   end

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
   import ir_carrier_pkg::*;
#(
   parameter int unsigned PER_THIRD    = 12,
   parameter int unsigned HIGH_THIRD   = 4,
   parameter int unsigned PER_QUARTER  = 12,
   parameter int unsigned HIGH_QUARTER = 3,
   parameter int unsigned PER_HALF     = 8,
   parameter int unsigned HIGH_HALF    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic       latch_in,
   output logic       carrier_out
);

   localparam int unsigned MAX_PER = max3(PER_THIRD, PER_QUARTER, PER_HALF);
   localparam int unsigned CNT_W   = (MAX_PER > 2) ? $clog2(MAX_PER) : 1;

   logic             latch_q;
   logic             hold_zero;
   logic             wrap;
   logic             mode_load;
   logic             phase_high;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_val;
   carrier_mode_e    active_mode;
   carrier_mode_e    mode_req;

   assign mode_req = carrier_mode_e'(mode_sel);

   // Enable register: the first edge that sees the latch high starts a burst.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= latch_in;
   end

   // Counter parks at zero while idle and on the burst's first edge.
   assign hold_zero = !latch_in || !latch_q;
   // The shape may change only where the counter restarts a period.
   assign mode_load = hold_zero || wrap;

   ir_mode_holder u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mode_load),
      .mode_in (mode_req),
      .mode_q  (active_mode)
   );

   ir_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_zero (hold_zero),
      .last_val  (last_val),
      .cnt       (cnt),
      .wrap      (wrap)
   );

   ir_phase_decode #(
      .CNT_W        (CNT_W),
      .PER_THIRD    (PER_THIRD),
      .HIGH_THIRD   (HIGH_THIRD),
      .PER_QUARTER  (PER_QUARTER),
      .HIGH_QUARTER (HIGH_QUARTER),
      .PER_HALF     (PER_HALF),
      .HIGH_HALF    (HIGH_HALF)
   ) u_dec (
      .mode       (active_mode),
      .cnt        (cnt),
      .phase_high (phase_high),
      .last_val   (last_val)
   );

   // Registered pin: no decode glitch reaches the LED driver.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carrier_out <= 1'b0;
      else        carrier_out <= latch_q && phase_high;
   end

   // R2: an idle enable register forces the pin low on the next edge.
   a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_q |=> !carrier_out);

   // R7: a burst opens with a high clock one edge after the restart edge.
   a_r7_first_high: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_in && !latch_q) |=> ##1 carrier_out);

   // R6: in the no-carrier shape the pin tracks the enable register.
   a_r6_steady_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mode == CM_STEADY && latch_q) |=> carrier_out);

   // R8: mid-period the shape in force does not move.
   a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && latch_in && cnt != '0) |-> $stable(active_mode));

endmodule

// File: tb/sim_ir_carrier_gen.sv
module sim_ir_carrier_gen;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       latch_in = 1'b0;
   logic       carrier_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ir_carrier_gen u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_sel    (mode_sel),
      .latch_in    (latch_in),
      .carrier_out (carrier_out)
   );

   // Shape table taken from the requirements (R3, R4, R5, R6).
   function automatic int per_of(input logic [1:0] m);
      case (m)
         2'b00: return 12;
         2'b01: return 12;
         2'b10: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int hi_of(input logic [1:0] m);
      case (m)
         2'b00: return 4;
         2'b01: return 3;
         2'b10: return 4;
         default: return 1;
      endcase
   endfunction

   function automatic logic shape_at(input logic [1:0] m, input int s);
      return ((s % per_of(m)) < hi_of(m));
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input logic exp, input string req, input int idx);
      n_vec++;
      if (carrier_out !== exp) begin
         n_bad++;
         $display("FAIL %s sample %0d: carrier_out=%b expected=%b", req, idx, carrier_out, exp);
      end
   endtask

   // Burst in mode a; if j0 >= 2, mode b is requested so that count j0 sees it.
   task automatic burst(input logic [1:0] a, input int j0, input logic [1:0] b,
                        input int nsamp, input string req);
      int bnd;
      bnd = (j0 >= 2) ? ((j0 + per_of(a) - 1) / per_of(a)) * per_of(a) : 1 << 30;
      mode_sel = a;
      latch_in = 1'b1;
      step();                       // edge k: burst starts at count 0
      for (int s = 0; s < nsamp; s++) begin
         step();                    // pin shows count s after edge k+1+s
         if (s >= bnd) check(shape_at(b, s - bnd), req, s);
         else          check(shape_at(a, s), req, s);
         if (j0 >= 2 && s + 2 == j0) mode_sel = b;
      end
      latch_in = 1'b0;
      step();
      step();
      check(1'b0, "R2", -1);
   endtask

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check(1'b0, "R1", 0);
      end
      rst_n = 1'b1;
      // R1/R2: latch low in every mode keeps the pin low
      for (int m = 0; m < 4; m++) begin
         mode_sel = 2'(m);
         for (int c = 0; c < 14; c++) begin
            step();
            check(1'b0, (m == 0) ? "R1" : "R2", c);
         end
      end

      // R3, R4, R5 and R7: three full periods from each rising edge
      burst(2'b00, -1, 2'b00, 36, "R3");
      burst(2'b01, -1, 2'b01, 36, "R4");
      burst(2'b10, -1, 2'b10, 24, "R5");
      burst(2'b00, -1, 2'b00, 12, "R7");

      // R8: mid-period switches take effect at the next boundary
      burst(2'b00, 5, 2'b10, 40, "R8");
      burst(2'b10, 3, 2'b01, 40, "R8");
      burst(2'b01, 12, 2'b00, 40, "R8");
      burst(2'b10, 9, 2'b11, 30, "R8");

      // R6: no-carrier shape follows the latch two edges late
      begin
         logic h1, h2;
         logic [7:0] lf;
         h1 = 1'b0; h2 = 1'b0; lf = 8'h5b;
         mode_sel = 2'b11;
         for (int c = 0; c < 120; c++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            latch_in = lf[0];
            h2 = h1; h1 = lf[0];
            step();
            check(h2, "R6", c);
         end
         latch_in = 1'b0;
         step(); step();
      end

      // R9: fall inside the high phase, then R7 restart gives a full period
      mode_sel = 2'b00;
      latch_in = 1'b1;
      step();
      step(); check(1'b1, "R9", 0);
      step(); check(1'b1, "R9", 1);
      latch_in = 1'b0;              // sampled low at edge k+3
      step(); check(1'b1, "R9", 2);
      for (int c = 3; c < 10; c++) begin
         step(); check(1'b0, "R9", c);
      end
      burst(2'b00, -1, 2'b00, 12, "R7");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule